// File: doc/BRIEF.md
# Masked Multi-Register Return Sequencer

This block carries out a processor's return-from-subroutine operation as a short multi-cycle sequence. It receives a 16-bit instruction field with a flag that picks the normal or the fast return variant. The field's low byte is an unsigned stack adjustment and its high byte is a register mask. On a start pulse the block adds the adjustment to the incoming stack pointer and holds the result for the rest of the operation. It then walks the mask in a fixed order. For each set bit it reads one 32-bit word from memory and writes that word into the register file. The reads move one word lower each time, starting one word below the adjusted stack pointer. Last, it sets the program counter.

The memory side is a read port with a valid/ready request channel and a valid/ready response channel, and only one read is in flight at a time. The register-file side is a single write port, driven in the cycle a response is accepted. The enclosing pipeline supplies the current stack pointer and MDR value with the start pulse. It then waits for the one-cycle done pulse and takes the new stack pointer and program counter from the block's outputs.

Top module: `ret_unwind_seq`

## Requirements
- R1: One cycle after an accepted start, `sp_o` equals `sp_i + instr_i[7:0]` (zero-extended, wrapping modulo 2^32).
- R2: The k-th restore read (k = 1, 2, ...) is issued at address `sp_o - 4*k`, wrapping modulo 2^32.
- R3: Mask bits are visited in the order 7, 6, 5, 4, 3. Bits 7, 6, 5 and 4 restore register indices 2 (D2), 3 (D3), 6 (A2) and 7 (A3). Bits 2:0 of the mask select nothing.
- R4: Mask bit 3 restores seven registers on consecutive lower words, in this order: index 0 (D0), 1 (D1), 4 (A0), 5 (A1), 8 (MDR), 9 (LIR), 10 (LAR).
- R5: A cleared mask bit issues no read. With an all-zero mask the only read is the normal-return program counter read, and a fast return issues no read at all.
- R6: `sp_o` does not change from the cycle after start until the operation has finished.
- R7: For a normal return, after all restores, one read at the adjusted stack pointer is made. The returned word becomes `pc_o` unchanged. The memory delivers bytes little-endian, with the lowest address in bits 7:0.
- R8: For a fast return, `pc_o` becomes the `mdr_i` value captured at start minus 3, wrapping. Restores in the same operation do not affect it.
- R9: A read request stays valid with a stable address until it is accepted. No new request is raised while a response is outstanding. Each accepted response is written to the register file in that same cycle, with `rf_wdata_o` equal to the response data.
- R10: A start pulse while an operation is in progress is ignored.
- R11: `done_o` is high for exactly one cycle per operation. It is high in the cycle after `pc_o` takes its new value.
- R12: While reset is asserted, no read is requested, no write or done is signalled, and `sp_o` and `pc_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one return operation |
| fast_i | input | 1 | 1 selects fast return, 0 normal return |
| instr_i | input | 16 | [7:0] stack adjustment, [15:8] register mask |
| sp_i | input | 32 | Stack pointer before the operation |
| mdr_i | input | 32 | MDR contents before the operation |
| mem_rd_valid_o | output | 1 | Read request valid |
| mem_rd_ready_i | input | 1 | Read request accepted |
| mem_rd_addr_o | output | 32 | Read byte address |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_ready_o | output | 1 | Read response accepted |
| mem_rsp_data_i | input | 32 | Read response word |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 4 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| sp_o | output | 32 | Adjusted stack pointer |
| pc_o | output | 32 | Program counter |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The main function is run with masks of several shapes: a single high bit, a full mask, the group bit alone, an empty mask, sparse masks with gaps, and masks whose three low bits are set. The read and write sequences of these runs separate a wrong visiting order, a wrong register index, a skipped or extra read, and a low bit that is wrongly decoded. Both return variants are run with both zero and nonzero masks, so that a fast return reading its MDR after a restore, or making a stray read, shows up in `pc_o` or in the read count. One stack value that wraps past zero, varying stall and latency on the memory channels, a start pulse injected mid-operation, and a reset mid-operation probe the address arithmetic, the handshake and the control corner cases.

// File: rtl/ret_unwind_pkg.sv
package ret_unwind_pkg;

  // single-register mask bits visited before the group bit
  localparam int N_SINGLE = 4;
  // registers restored by the group bit
  localparam int GROUP_N  = 7;
  localparam int NSLOT    = N_SINGLE + GROUP_N;
  localparam int SLOT_W   = $clog2(NSLOT + 1);
  localparam int SEL_W    = N_SINGLE + 1;
  localparam int RF_AW    = 4;

  // register-file indices
  localparam logic [RF_AW-1:0] RID_D0  = 4'd0;
  localparam logic [RF_AW-1:0] RID_D1  = 4'd1;
  localparam logic [RF_AW-1:0] RID_D2  = 4'd2;
  localparam logic [RF_AW-1:0] RID_D3  = 4'd3;
  localparam logic [RF_AW-1:0] RID_A0  = 4'd4;
  localparam logic [RF_AW-1:0] RID_A1  = 4'd5;
  localparam logic [RF_AW-1:0] RID_A2  = 4'd6;
  localparam logic [RF_AW-1:0] RID_A3  = 4'd7;
  localparam logic [RF_AW-1:0] RID_MDR = 4'd8;
  localparam logic [RF_AW-1:0] RID_LIR = 4'd9;
  localparam logic [RF_AW-1:0] RID_LAR = 4'd10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RSP,
    ST_PC_REQ,
    ST_PC_RSP,
    ST_PC_FAST,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/ret_unwind_slot_pick.sv
module ret_unwind_slot_pick
  import ret_unwind_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,   // [SEL_W-1] visited first, [0] is the group bit
  input  logic [SLOT_W-1:0] from_i,  // first slot eligible
  output logic              found_o,
  output logic [SLOT_W-1:0] slot_o
);

  logic [NSLOT-1:0] slot_en;

  for (genvar g = 0; g < NSLOT; g++) begin : g_en
    if (g < N_SINGLE) begin : g_single
      assign slot_en[g] = sel_i[SEL_W-1-g];
    end else begin : g_group
      assign slot_en[g] = sel_i[0];
    end
  end

  // lowest enabled slot at or after from_i
  always_comb begin
    found_o = 1'b0;
    slot_o  = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slot_en[i] && (SLOT_W'(i) >= from_i)) begin
        found_o = 1'b1;
        slot_o  = SLOT_W'(i);
      end
    end
  end

endmodule

// File: rtl/ret_unwind_reg_map.sv
module ret_unwind_reg_map
  import ret_unwind_pkg::*;
(
  input  logic [SLOT_W-1:0] slot_i,
  output logic [RF_AW-1:0]  rid_o
);

  always_comb begin
    unique case (slot_i)
      SLOT_W'(0):  rid_o = RID_D2;
      SLOT_W'(1):  rid_o = RID_D3;
      SLOT_W'(2):  rid_o = RID_A2;
      SLOT_W'(3):  rid_o = RID_A3;
      SLOT_W'(4):  rid_o = RID_D0;
      SLOT_W'(5):  rid_o = RID_D1;
      SLOT_W'(6):  rid_o = RID_A0;
      SLOT_W'(7):  rid_o = RID_A1;
      SLOT_W'(8):  rid_o = RID_MDR;
      SLOT_W'(9):  rid_o = RID_LIR;
      SLOT_W'(10): rid_o = RID_LAR;
      default:     rid_o = RID_D0;
    endcase
  end

endmodule

// File: rtl/ret_unwind_seq.sv
module ret_unwind_seq
  import ret_unwind_pkg::*;
#(
  parameter int DW     = 32,
  parameter int ADJ_W  = 8,
  parameter int MASK_W = 8,
  parameter int FAST_SUB = 3,
  localparam int IW    = ADJ_W + MASK_W,
  localparam int WORD_BYTES = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fast_i,
  input  logic [IW-1:0]     instr_i,
  input  logic [DW-1:0]     sp_i,
  input  logic [DW-1:0]     mdr_i,
  output logic              mem_rd_valid_o,
  input  logic              mem_rd_ready_i,
  output logic [DW-1:0]     mem_rd_addr_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  input  logic [DW-1:0]     mem_rsp_data_i,
  output logic              rf_we_o,
  output logic [RF_AW-1:0]  rf_waddr_o,
  output logic [DW-1:0]     rf_wdata_o,
  output logic [DW-1:0]     sp_o,
  output logic [DW-1:0]     pc_o,
  output logic              done_o
);

  seq_state_e        state_q, state_d;
  logic [DW-1:0]     sp_q, sp_d;
  logic [DW-1:0]     addr_q, addr_d;
  logic [DW-1:0]     pc_q, pc_d;
  logic [DW-1:0]     mdr_q;
  logic [SEL_W-1:0]  sel_q;
  logic              fast_q;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              cap_en, addr_en, slot_en, pc_en;

  logic [SEL_W-1:0]  pick_sel;
  logic [SLOT_W-1:0] pick_from;
  logic              pick_found;
  logic [SLOT_W-1:0] pick_slot;
  logic [RF_AW-1:0]  cur_rid;

  logic              unused_mask_bits;
  assign unused_mask_bits = ^instr_i[IW-SEL_W-1:ADJ_W];

  // picker sees the live mask at start, the captured one afterwards
  assign pick_sel  = (state_q == ST_IDLE) ? instr_i[IW-1 -: SEL_W] : sel_q;
  assign pick_from = (state_q == ST_IDLE) ? '0 : slot_q + SLOT_W'(1);

  ret_unwind_slot_pick u_pick (
    .sel_i   (pick_sel),
    .from_i  (pick_from),
    .found_o (pick_found),
    .slot_o  (pick_slot)
  );

  ret_unwind_reg_map u_map (
    .slot_i (slot_q),
    .rid_o  (cur_rid)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    sp_d    = sp_q;
    addr_d  = addr_q;
    pc_d    = pc_q;
    slot_d  = slot_q;
    cap_en  = 1'b0;
    addr_en = 1'b0;
    slot_en = 1'b0;
    pc_en   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          cap_en  = 1'b1;
          addr_en = 1'b1;
          sp_d    = sp_i + DW'(instr_i[ADJ_W-1:0]);
          addr_d  = sp_d - DW'(WORD_BYTES);
          if (pick_found) begin
            slot_en = 1'b1;
            slot_d  = pick_slot;
            state_d = ST_REQ;
          end else begin
            state_d = fast_i ? ST_PC_FAST : ST_PC_REQ;
          end
        end
      end
      ST_REQ: begin
        if (mem_rd_ready_i) state_d = ST_RSP;
      end
      ST_RSP: begin
        if (mem_rsp_valid_i) begin
          addr_en = 1'b1;
          addr_d  = addr_q - DW'(WORD_BYTES);
          if (pick_found) begin
            slot_en = 1'b1;
            slot_d  = pick_slot;
            state_d = ST_REQ;
          end else begin
            state_d = fast_q ? ST_PC_FAST : ST_PC_REQ;
          end
        end
      end
      ST_PC_REQ: begin
        if (mem_rd_ready_i) state_d = ST_PC_RSP;
      end
      ST_PC_RSP: begin
        if (mem_rsp_valid_i) begin
          pc_en   = 1'b1;
          pc_d    = mem_rsp_data_i;
          state_d = ST_DONE;
        end
      end
      ST_PC_FAST: begin
        pc_en   = 1'b1;
        pc_d    = mdr_q - DW'(FAST_SUB);
        state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sp_q    <= '0;
      addr_q  <= '0;
      pc_q    <= '0;
      mdr_q   <= '0;
      sel_q   <= '0;
      fast_q  <= 1'b0;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        sp_q   <= sp_d;
        mdr_q  <= mdr_i;
        sel_q  <= instr_i[IW-1 -: SEL_W];
        fast_q <= fast_i;
      end
      if (addr_en) addr_q <= addr_d;
      if (slot_en) slot_q <= slot_d;
      if (pc_en)   pc_q   <= pc_d;
    end
  end

  // outputs
  assign mem_rd_valid_o  = (state_q == ST_REQ) || (state_q == ST_PC_REQ);
  assign mem_rd_addr_o   = (state_q == ST_PC_REQ) ? sp_q : addr_q;
  assign mem_rsp_ready_o = (state_q == ST_RSP) || (state_q == ST_PC_RSP);
  assign rf_we_o         = (state_q == ST_RSP) && mem_rsp_valid_i;
  assign rf_waddr_o      = cur_rid;
  assign rf_wdata_o      = mem_rsp_data_i;
  assign sp_o            = sp_q;
  assign pc_o            = pc_q;
  assign done_o          = (state_q == ST_DONE);

endmodule

// File: rtl/ret_unwind_chk.sv
module ret_unwind_chk #(
  parameter int DW = 32,
  parameter int IW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          start_i,
  input logic [IW-1:0] instr_i,
  input logic [DW-1:0] sp_i,
  input logic          mem_rd_valid_o,
  input logic          mem_rd_ready_i,
  input logic [DW-1:0] mem_rd_addr_o,
  input logic          mem_rsp_valid_i,
  input logic          mem_rsp_ready_o,
  input logic          rf_we_o,
  input logic [DW-1:0] sp_o,
  input logic          done_o
);

  a_r1_sp_adjust: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_i) |=> (sp_o == $past(sp_i) + DW'($past(instr_i[7:0]))));

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid_o |-> (mem_rd_addr_o[1:0] == sp_o[1:0]));

  a_r6_sp_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sp_o));

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid_o && !mem_rd_ready_i) |=> (mem_rd_valid_o && $stable(mem_rd_addr_o)));

  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_valid_o && mem_rsp_ready_o));

  a_r9_write_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (mem_rsp_valid_i && mem_rsp_ready_o));

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> $stable(sp_o));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r12_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!mem_rd_valid_o && !rf_we_o && !done_o));

endmodule

bind ret_unwind_seq ret_unwind_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .busy            (state_q != ST_IDLE),
  .start_i         (start_i),
  .instr_i         (instr_i),
  .sp_i            (sp_i),
  .mem_rd_valid_o  (mem_rd_valid_o),
  .mem_rd_ready_i  (mem_rd_ready_i),
  .mem_rd_addr_o   (mem_rd_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .mem_rsp_ready_o (mem_rsp_ready_o),
  .rf_we_o         (rf_we_o),
  .sp_o            (sp_o),
  .done_o          (done_o)
);

// File: tb/ret_unwind_seq_bench.sv
`timescale 1ns/1ps
module ret_unwind_seq_bench;

  typedef struct packed {
    logic        fast;
    logic [15:0] instr;
    logic [31:0] sp;
    logic [31:0] mdr;
    logic [1:0]  lat;
    logic        stall;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 16'h8010, 32'h0000_1000, 32'h0000_0000, 2'd0, 1'b0},
    '{1'b0, 16'hF820, 32'h0000_2000, 32'h1234_5678, 2'd2, 1'b1},
    '{1'b1, 16'h0800, 32'h0000_3000, 32'h0000_0400, 2'd1, 1'b0},
    '{1'b0, 16'h00FF, 32'h0000_4000, 32'h0000_0000, 2'd0, 1'b0},
    '{1'b1, 16'h0000, 32'h0000_5000, 32'h0000_0001, 2'd0, 1'b0},
    '{1'b0, 16'h5010, 32'hFFFF_FFF8, 32'h0000_0000, 2'd1, 1'b1},
    '{1'b1, 16'hA804, 32'h0000_6000, 32'hCAFE_0003, 2'd1, 1'b1},
    '{1'b0, 16'h2730, 32'h0000_7000, 32'h0000_0000, 2'd0, 1'b0}
  };

  logic        clk, rst_n;
  logic        start_i, fast_i;
  logic [15:0] instr_i;
  logic [31:0] sp_i, mdr_i;
  logic        mem_rd_valid_o, mem_rd_ready_i;
  logic [31:0] mem_rd_addr_o;
  logic        mem_rsp_valid_i, mem_rsp_ready_o;
  logic [31:0] mem_rsp_data_i;
  logic        rf_we_o;
  logic [3:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o, sp_o, pc_o;
  logic        done_o;

  ret_unwind_seq u_ret_unwind_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fast_i(fast_i),
    .instr_i(instr_i), .sp_i(sp_i), .mdr_i(mdr_i),
    .mem_rd_valid_o(mem_rd_valid_o), .mem_rd_ready_i(mem_rd_ready_i),
    .mem_rd_addr_o(mem_rd_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_ready_o(mem_rsp_ready_o), .mem_rsp_data_i(mem_rsp_data_i),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .sp_o(sp_o), .pc_o(pc_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // memory model state
  int          cyc = 0;
  bit          pending, acc_req, acc_rsp, stall_mode;
  int          lat_cfg, lat_cnt;
  logic [31:0] pend_addr;
  bit          done_seen;

  // observation logs
  logic [31:0] rd_addr [16];
  logic [3:0]  wr_id   [16];
  logic [31:0] wr_data [16];
  int          n_rd, n_wr, n_done;

  // expectations
  logic [31:0] ex_addr [16];
  logic [3:0]  ex_id   [16];
  int          ex_rd, ex_wr;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    n_rd = 0; n_wr = 0; n_done = 0;
  endtask

  // one clock: drive at negedge, then log what the next posedge will see
  task automatic tick();
    @(negedge clk);
    cyc++;
    if (!rst_n) begin
      pending = 0; acc_req = 0; acc_rsp = 0;
      mem_rsp_valid_i = 1'b0;
    end else begin
      if (acc_rsp) begin mem_rsp_valid_i = 1'b0; pending = 0; end
      if (acc_req) begin pending = 1; lat_cnt = lat_cfg; end
      if (pending && !mem_rsp_valid_i) begin
        if (lat_cnt == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = memf(pend_addr);
        end else lat_cnt--;
      end
    end
    mem_rd_ready_i = stall_mode ? ((cyc % 3) == 2) : 1'b1;
    #1;
    acc_req = mem_rd_valid_o && mem_rd_ready_i;
    if (acc_req) begin
      pend_addr = mem_rd_addr_o;
      if (n_rd < 16) rd_addr[n_rd] = mem_rd_addr_o;
      n_rd++;
    end
    acc_rsp = mem_rsp_valid_i && mem_rsp_ready_o;
    if (rf_we_o) begin
      if (n_wr < 16) begin wr_id[n_wr] = rf_waddr_o; wr_data[n_wr] = rf_wdata_o; end
      n_wr++;
    end
    done_seen = done_o;
    if (done_o) n_done++;
  endtask

  task automatic build_exp(input vec_t v);
    logic [31:0] spa;
    logic [3:0]  ids [11];
    ids = '{4'd2, 4'd3, 4'd6, 4'd7, 4'd0, 4'd1, 4'd4, 4'd5, 4'd8, 4'd9, 4'd10};
    spa = v.sp + {24'd0, v.instr[7:0]};
    ex_rd = 0; ex_wr = 0;
    for (int s = 0; s < 11; s++) begin
      logic en;
      en = (s < 4) ? v.instr[15 - s] : v.instr[11];
      if (en) begin
        ex_id[ex_wr]   = ids[s];
        ex_addr[ex_rd] = spa - 32'(4 * (ex_rd + 1));
        ex_wr++; ex_rd++;
      end
    end
    if (!v.fast) begin ex_addr[ex_rd] = spa; ex_rd++; end
  endtask

  task automatic run_op(input vec_t v, input bit inject, input string tag);
    logic [31:0] spa;
    int t;
    spa = v.sp + {24'd0, v.instr[7:0]};
    build_exp(v);
    clear_logs();
    lat_cfg = int'(v.lat); stall_mode = v.stall;
    fast_i = v.fast; instr_i = v.instr; sp_i = v.sp; mdr_i = v.mdr;
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    // scramble live inputs: the operation must use captured values
    sp_i = ~v.sp; mdr_i = ~v.mdr; instr_i = 16'h0000; fast_i = ~v.fast;
    chk("R1", sp_o, spa, {tag, " adjusted sp"});
    t = 0;
    while (!done_seen && t < 400) begin
      if (inject && t == 3) begin
        start_i = 1'b1; instr_i = 16'h0808; sp_i = 32'h9999_0000;
      end
      tick();
      start_i = 1'b0;
      t++;
    end
    if (!done_seen) chk("R11", 32'd0, 32'd1, {tag, " done never seen"});
    chk("R6", sp_o, spa, {tag, " sp held at end"});
    if (inject) chk("R10", sp_o, spa, {tag, " sp after ignored start"});
    tick();
    chk("R11", 32'(n_done), 32'd1, {tag, " done cycles"});
    chk("R5", 32'(n_rd), 32'(ex_rd), {tag, " read count"});
    for (int k = 0; k < ex_rd && k < n_rd; k++)
      chk((!v.fast && k == ex_rd - 1) ? "R7" : "R2", rd_addr[k], ex_addr[k], {tag, " read address"});
    chk("R9", 32'(n_wr), 32'(ex_wr), {tag, " write count"});
    for (int k = 0; k < ex_wr && k < n_wr; k++) begin
      chk((ex_id[k] == 4'd2 || ex_id[k] == 4'd3 || ex_id[k] == 4'd6 || ex_id[k] == 4'd7) ? "R3" : "R4",
          {28'd0, wr_id[k]}, {28'd0, ex_id[k]}, {tag, " write index"});
      chk("R9", wr_data[k], memf(ex_addr[k]), {tag, " write data"});
    end
    if (v.fast) chk("R8", pc_o, v.mdr - 32'd3, {tag, " fast pc"});
    else        chk("R7", pc_o, memf(spa), {tag, " normal pc"});
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    rst_n = 1'b1;
    start_i = 1'b0; fast_i = 1'b0; instr_i = '0; sp_i = '0; mdr_i = '0;
    mem_rd_ready_i = 1'b0; mem_rsp_valid_i = 1'b0; mem_rsp_data_i = '0;
    pending = 0; acc_req = 0; acc_rsp = 0; stall_mode = 0; lat_cfg = 0; lat_cnt = 0;
    pend_addr = '0; done_seen = 0;
    clear_logs();
    #2 rst_n = 1'b0;
    tick(); tick();
    // R12: reset state
    chk("R12", {31'd0, mem_rd_valid_o}, 32'd0, "valid in reset");
    chk("R12", {31'd0, done_o}, 32'd0, "done in reset");
    chk("R12", sp_o, 32'd0, "sp in reset");
    chk("R12", pc_o, 32'd0, "pc in reset");
    @(negedge clk) rst_n = 1'b1;
    tick();

    for (int i = 0; i < NVEC; i++) run_op(VECS[i], 1'b0, $sformatf("vec%0d", i));

    // R10: start pulse during a busy operation
    run_op(VECS[1], 1'b1, "busy-start");

    // R12: reset in the middle of an operation
    clear_logs();
    lat_cfg = 3; stall_mode = 0;
    fast_i = 1'b0; instr_i = 16'hF800; sp_i = 32'h0000_8000; mdr_i = '0;
    start_i = 1'b1; tick(); start_i = 1'b0;
    tick(); tick();
    @(negedge clk) rst_n = 1'b0;
    tick();
    chk("R12", {31'd0, mem_rd_valid_o}, 32'd0, "valid after mid reset");
    chk("R12", {31'd0, rf_we_o}, 32'd0, "write after mid reset");
    chk("R12", sp_o, 32'd0, "sp after mid reset");
    @(negedge clk) rst_n = 1'b1;
    tick();
    run_op(VECS[0], 1'b0, "after-reset");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule